// File: doc/BRIEF.md
# SHA-3 Rate Buffer and Padder

This block collects a message for a SHA3-512 style sponge, one 64-bit word per write, into a 576-bit rate block made of nine 64-bit lanes. The first word written after a block is consumed goes to lane 0, the next to lane 1, and so on. Inside each lane, byte 0 of the word occupies bits 7:0 (little-endian). Once all nine lanes are written, the block is offered to a downstream permutation engine. Input is refused until that engine signals that it has absorbed the block.

The last word of a message is written with the final flag set and a 3-bit byte count. The block keeps only that many low-order bytes of the word. It then applies the SHA-3 multi-rate padding: the domain byte 0x06 goes right after the last message byte, and bit 7 of the block's last byte is set. The result is offered as the last block. A message that ends exactly on a block boundary is closed with a final write that carries zero bytes. That write produces a block made only of padding.

Top module: `sha3_rate_padder`

## Requirements
- R1: After reset, in_ready is 1, blk_valid is 0, blk_last is 0 and blk_data is all zero.
- R2: An accepted non-final write of word number k since the last block (k counted from 0) lands unchanged in blk_data bits 64k+63 down to 64k. No block is offered before the ninth word.
- R3: The cycle after the ninth accepted non-final write, blk_valid is 1, blk_last is 0 and in_ready is 0. blk_data then holds all nine words.
- R4: While blk_valid is 1 and perm_done is 0, writes are ignored: blk_data, blk_valid and blk_last keep their values.
- R5: perm_done sampled while blk_valid is 1 makes the next cycle show blk_valid 0, blk_last 0, in_ready 1 and blk_data all zero. The next word then goes to lane 0.
- R6: A final write with byte count n (0 to 7) into lane k behaves as follows. Bytes 0 to n-1 of the word are kept and its other bytes are cleared. Byte n of lane k gets 0x06. Bit 575 of the block is set, which is 0x80 in byte 71. All later lanes stay zero. The next cycle shows blk_valid 1, blk_last 1 and in_ready 0.
- R7: A final write into lane 8 with n equal to 7 puts both padding marks in byte 71, which then reads 0x86.
- R8: A final write with n equal to 0 as the first word of a block gives a pure padding block. That block holds 0x06 in byte 0 and 0x80 in byte 71, and every other bit is zero.
- R9: perm_done while blk_valid is 0 has no effect. The lanes written so far and the write position are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one message word |
| wr_data | input | 64 | Message word, byte 0 in bits 7:0 |
| wr_last | input | 1 | Marks the word as the last one of the message |
| wr_nbytes | input | 3 | Valid low-order bytes of a last word (0 to 7) |
| in_ready | output | 1 | Writes are accepted while high |
| perm_done | input | 1 | Engine has absorbed the offered block |
| blk_data | output | 576 | Rate block, lane k in bits 64k+63:64k |
| blk_valid | output | 1 | A complete block is offered |
| blk_last | output | 1 | The offered block is the padded last block |

## Verification
Every result is due one clock after the write or perm_done that causes it. An accepted write is captured at one rising edge. Its lane contents, blk_valid, blk_last and in_ready are visible from just after that edge. The bench drives inputs on the falling edge and holds them for one full cycle. It samples outputs on the following falling edge, half a cycle after the edge that registered them. That places each check in the first cycle where the new value must appear. The same timing is used to confirm that ignored writes and idle perm_done pulses leave the outputs unchanged in that cycle.

// File: rtl/sha3_rate_padder.sv
module sha3_rate_padder #(
  parameter int LANE_W = 64,
  parameter int LANES  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [LANE_W-1:0]         wr_data,
  input  logic                      wr_last,
  input  logic [2:0]                wr_nbytes,
  output logic                      in_ready,
  input  logic                      perm_done,
  output logic [LANE_W*LANES-1:0]   blk_data,
  output logic                      blk_valid,
  output logic                      blk_last
);
  localparam int RATE  = LANE_W * LANES;
  localparam int NBYTE = LANE_W / 8;
  localparam int CW    = $clog2(LANES);

  logic [LANE_W-1:0] lane_q [LANES];
  logic [CW-1:0]     fill_q;
  logic              busy_q, last_q;
  logic [LANE_W-1:0] keep_mask, tail_word;

  wire accept  = wr_en & ~busy_q;
  wire at_end  = (fill_q == CW'(LANES - 1));

  always_comb begin
    keep_mask = '0;
    for (int b = 0; b < NBYTE; b++)
      if (wr_nbytes > 3'(b)) keep_mask[b*8 +: 8] = 8'hFF;
    tail_word = (wr_data & keep_mask) | (LANE_W'(8'h06) << {wr_nbytes, 3'b000});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
      fill_q <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (busy_q) begin
      if (perm_done) begin
        for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
        fill_q <= '0;
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end
    end else if (accept) begin
      if (wr_last) begin
        lane_q[fill_q] <= tail_word;
        lane_q[LANES-1][LANE_W-1] <= 1'b1;
        busy_q <= 1'b1;
        last_q <= 1'b1;
      end else begin
        lane_q[fill_q] <= wr_data;
        if (at_end) busy_q <= 1'b1;
        else        fill_q <= fill_q + CW'(1);
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign blk_data[g*LANE_W +: LANE_W] = lane_q[g];
  end

  assign in_ready  = ~busy_q;
  assign blk_valid = busy_q;
  assign blk_last  = last_q;

  a_r3_block_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_valid) |-> $past(wr_en));

  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !perm_done) |=> (blk_valid && $stable(blk_data) && $stable(blk_last)));

  a_r5_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && perm_done) |=> (!blk_valid && !blk_last && blk_data == '0));

  a_r6_last_padded: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last |-> (blk_valid && blk_data[RATE-1]));

  a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && perm_done && !wr_en) |=> (!blk_valid && $stable(blk_data)));
endmodule

// File: tb/sha3_rate_padder_tb.sv
module sha3_rate_padder_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_last = 0, perm_done = 0;
  logic [63:0] wr_data = '0;
  logic [2:0] wr_nbytes = '0;
  logic in_ready, blk_valid, blk_last;
  logic [575:0] blk_data;
  int applied = 0, miscomp = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sha3_rate_padder u_dut (.clk, .rst_n, .wr_en, .wr_data, .wr_last, .wr_nbytes,
    .in_ready, .perm_done, .blk_data, .blk_valid, .blk_last);

  // {words before final, final byte count}
  localparam int VEC [8][2] = '{'{0,0}, '{0,3}, '{1,7}, '{4,5},
                                '{8,7}, '{8,0}, '{3,1}, '{7,2}};

  function automatic logic [63:0] pat(int v, int k);
    return 64'hA5C3_0F1E_2D3C_4B5A ^ (64'(k + 1) * 64'h0101_0101_0101_0101) ^ (64'(v) << 40);
  endfunction

  function automatic logic [575:0] expect_blk(int v, int nw, int nb);
    logic [575:0] e = '0;
    logic [63:0] w;
    for (int k = 0; k < nw; k++) e[k*64 +: 64] = pat(v, k);
    w = pat(v, nw);
    for (int b = 0; b < 8; b++) if (b >= nb) w[b*8 +: 8] = 8'h00;
    w[nb*8 +: 8] = w[nb*8 +: 8] | 8'h06;
    e[nw*64 +: 64] = w;
    e[575] = 1'b1;
    return e;
  endfunction

  task automatic check(string tag, logic [575:0] act, logic [575:0] exp);
    applied++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(logic [63:0] d, logic l, logic [2:0] n);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_last = l; wr_nbytes = n;
    @(negedge clk);
    wr_en = 0; wr_last = 0;
  endtask

  task automatic pulse_done;
    @(negedge clk);
    perm_done = 1;
    @(negedge clk);
    perm_done = 0;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    applied++; miscomp++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [575:0] snap, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ready", in_ready, 1);
    check("R1 valid", blk_valid, 0);
    check("R1 last", blk_last, 0);
    check("R1 data", blk_data, '0);

    // table walk: R6 / R7 / R8 variants
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < VEC[v][0]; k++) push(pat(v, k), 0, 3'd0);
      push(pat(v, VEC[v][0]), 1, 3'(VEC[v][1]));
      check("R6 valid", blk_valid, 1);
      check("R6 last", blk_last, 1);
      check("R6 ready", in_ready, 0);
      check(v == 4 ? "R7 data" : "R6 data", blk_data, expect_blk(v, VEC[v][0], VEC[v][1]));
      pulse_done();
      check("R5 cleared", blk_data, '0);
      check("R5 ready", in_ready, 1);
    end

    // R2: partial fill visible, no block yet
    e = '0;
    for (int k = 0; k < 3; k++) begin push(pat(20, k), 0, 3'd0); e[k*64 +: 64] = pat(20, k); end
    check("R2 lanes", blk_data, e);
    check("R2 no block", blk_valid, 0);
    // R9: idle done keeps lanes
    pulse_done();
    check("R9 lanes kept", blk_data, e);
    check("R9 no block", blk_valid, 0);
    // R3: complete to nine words
    for (int k = 3; k < 9; k++) begin push(pat(20, k), 0, 3'd0); e[k*64 +: 64] = pat(20, k); end
    check("R3 valid", blk_valid, 1);
    check("R3 not last", blk_last, 0);
    check("R3 ready", in_ready, 0);
    check("R3 data", blk_data, e);
    // R4: writes while busy ignored
    snap = blk_data;
    push(64'hDEAD_BEEF_0000_1111, 0, 3'd0);
    push(64'h1234_5678_9ABC_DEF0, 1, 3'd4);
    check("R4 data", blk_data, snap);
    check("R4 last", blk_last, 0);
    check("R4 valid", blk_valid, 1);
    pulse_done();
    check("R5 valid", blk_valid, 0);
    check("R5 data", blk_data, '0);
    // R8: boundary-closing pure padding block
    push(64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd0);
    e = '0; e[2:1] = 2'b11; e[575] = 1'b1;
    check("R8 data", blk_data, e);
    check("R8 last", blk_last, 1);
    pulse_done();
    finish_run();
  end
endmodule